// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Loader

This block loads a configuration image into an FPGA through the FPGA's byte-wide slave configuration port. Software or a higher-level engine issues a one-cycle start together with a byte count. The loader pulses the program line and waits for the target to report that it is ready. It then draws bytes from a valid/ready stream and presents each one on the configuration bus with one clock pulse. When the bytes are exhausted it keeps pulsing the clock until the target raises its done line. Three waits can stall: target readiness, target busy after a byte, and target done. Each has its own timeout. A timeout ends the load, pulses an abort output and records which wait failed.

With the read-back mode selected at start, the loader does not program the target. It selects the port with write disabled, pulses the clock once per requested byte and presents each sampled byte on a valid/data output. After deselection it gives one more clock pulse. The configuration clock half-period, the program pulse length and the timeout are parameters counted in system clock cycles. The half-period lets the port be held below the target's 50 MHz limit.

Top module: `pcfg_master`

## Requirements
- R1: A start with readMode=0 drives status to 1 (running) on the next cycle and raises progOut for exactly PROG_HOLD system cycles, once per load.
- R2: After progOut falls, data transfer waits until tgtInit=1 and tgtBusy=0. If that takes TIMEOUT cycles, the load ends with status 3 (failed), failCode 1 and one abortOut pulse.
- R3: Before the first byte, selOut and wrOut are high while cfgClk is high. inReady is high only while selOut, wrOut and cfgClk are all high.
- R4: Each accepted stream byte is held on cfgDout while cfgClk goes low for HALF_CYC cycles and then high for HALF_CYC cycles. The target sees exactly byteCount capturing rising edges, carrying the stream bytes in order.
- R5: With BUSY_CHECK set, if tgtBusy is high at the end of a byte's high phase, further clock pulses follow until tgtBusy is low. If busy persists for TIMEOUT cycles, the load fails with failCode 2 and one abortOut pulse.
- R6: After the last byte, selOut falls exactly one cycle before wrOut falls.
- R7: After deselection the loader pulses cfgClk (one pulse per unmet check) until tgtDone=1, then sets status 2 (success), failCode 0. If done does not arrive within TIMEOUT cycles, the load fails with failCode 3 and one abortOut pulse.
- R8: With readMode=1, progOut stays low and wrOut stays low. Each of byteCount clock pulses with selOut high yields one rbValid pulse, whose rbData is cfgDin sampled at the end of that pulse's high phase. Exactly one clock pulse follows with selOut low, then status becomes 2.
- R9: After reset, status=0 (idle), failCode=0, progOut=0, selOut=0, wrOut=0, cfgClk=1, abortOut=0, inReady=0 and rbValid=0.
- R10: start is ignored while status is 1. A second start during a load causes no second program pulse and does not change the bytes delivered.
- R11: A load with byteCount=0 selects and deselects the port with no data pulse, then runs the done phase as in R7.
- R12: cfgClk never holds a level for fewer than HALF_CYC system cycles, including at the phase boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle command to begin a load or read-back |
| readMode | input | 1 | 1 selects read-back, 0 selects load; sampled with start |
| byteCount | input | CNT_W | Number of bytes to transfer; sampled with start |
| inValid | input | 1 | Stream byte valid |
| inData | input | DATA_W | Stream byte |
| inReady | output | 1 | Loader accepts the stream byte this cycle |
| progOut | output | 1 | Program request to the target, active high |
| tgtInit | input | 1 | Target initialisation finished, active high |
| tgtBusy | input | 1 | Target busy, active high |
| tgtDone | input | 1 | Target configuration done, active high |
| selOut | output | 1 | Port chip select, active high |
| wrOut | output | 1 | Port write enable, active high |
| cfgClk | output | 1 | Configuration clock; idles high |
| cfgDout | output | DATA_W | Byte driven onto the configuration bus |
| cfgDin | input | DATA_W | Byte read from the configuration bus |
| rbValid | output | 1 | One-cycle pulse: rbData holds a read-back byte |
| rbData | output | DATA_W | Read-back byte |
| abortOut | output | 1 | One-cycle pulse when a wait times out |
| status | output | 2 | 0 idle, 1 running, 2 success, 3 failed |
| failCode | output | 2 | 0 none, 1 ready wait, 2 busy wait, 3 done wait |

## Verification
The assertions assume that start is pulsed for one cycle and that byteCount and readMode are stable when it is. They also assume the target lines change only after a configuration clock edge, so a level sampled at the end of a phase is settled. The bench models the target on the rising edge of cfgClk: a byte is captured only when the target is not busy, busy then holds for a chosen number of edges, and done rises after a chosen number of deselected edges. The inputs therefore change only at the moments a real target would change them. The stream always offers data, so every stall the loader shows is one it created itself.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [1:0] {
    STAT_IDLE = 2'd0,
    STAT_RUN  = 2'd1,
    STAT_OK   = 2'd2,
    STAT_ERR  = 2'd3
  } statE;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_READY = 2'd1,
    FC_BUSY  = 2'd2,
    FC_DONE  = 2'd3
  } failE;

  // control-to-datapath strobes
  typedef struct packed {
    logic stepClr;
    logic waitClr;
    logic cntLoad;
    logic cntDec;
    logic takeByte;
    logic sampleByte;
  } strobeS;

endpackage

// File: rtl/pcfg_dpath.sv
module pcfg_dpath
  import pcfg_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  parameter int STEP_W  = 4,
  parameter int TIMEOUT = 1000,
  parameter int WAIT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeS            stb,
  input  logic [CNT_W-1:0]  cntInit,
  input  logic [DATA_W-1:0] streamData,
  input  logic [DATA_W-1:0] cfgDin,
  output logic [STEP_W-1:0] stepCnt,
  output logic              cntZero,
  output logic              waitExpired,
  output logic [DATA_W-1:0] cfgDout,
  output logic [DATA_W-1:0] rbData,
  output logic              rbValid
);

  localparam logic [WAIT_W-1:0] WAIT_LIMIT = WAIT_W'(TIMEOUT);

  logic [WAIT_W-1:0] waitCnt;
  logic [CNT_W-1:0]  remaining;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                stepCnt <= '0;
    else if (stb.stepClr)     stepCnt <= '0;
    else if (stepCnt != '1)   stepCnt <= stepCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      waitCnt <= '0;
    else if (stb.waitClr)           waitCnt <= '0;
    else if (waitCnt < WAIT_LIMIT)  waitCnt <= waitCnt + 1'b1;
  end

  assign waitExpired = (waitCnt == WAIT_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              remaining <= '0;
    else if (stb.cntLoad)                   remaining <= cntInit;
    else if (stb.cntDec && remaining != '0) remaining <= remaining - 1'b1;
  end

  assign cntZero = (remaining == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDout <= '0;
      rbData  <= '0;
      rbValid <= 1'b0;
    end else begin
      if (stb.takeByte)   cfgDout <= streamData;
      if (stb.sampleByte) rbData  <= cfgDin;
      rbValid <= stb.sampleByte;
    end
  end

  // R4
  no_underrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntDec |-> !cntZero);

  // R2
  wait_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(waitExpired) && !$past(stb.waitClr)) |-> waitExpired);

endmodule

// File: rtl/pcfg_ctrl.sv
module pcfg_ctrl
  import pcfg_pkg::*;
#(
  parameter int HALF_CYC   = 2,
  parameter int PROG_HOLD  = 64,
  parameter int BUSY_CHECK = 1,
  parameter int STEP_W     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              readMode,
  input  logic              tgtInit,
  input  logic              tgtBusy,
  input  logic              tgtDone,
  input  logic              inValid,
  input  logic [STEP_W-1:0] stepCnt,
  input  logic              cntZero,
  input  logic              waitExpired,
  output strobeS            stb,
  output logic              progOut,
  output logic              selOut,
  output logic              wrOut,
  output logic              cfgClk,
  output logic              inReady,
  output logic              abortOut,
  output statE              status,
  output failE              failCode
);

  localparam logic [STEP_W-1:0] HALF_LAST = STEP_W'(HALF_CYC - 1);
  localparam logic [STEP_W-1:0] HOLD_LAST = STEP_W'(PROG_HOLD - 1);
  localparam bit               CHECK_BSY = (BUSY_CHECK != 0);

  typedef enum logic [4:0] {
    S_IDLE, S_PROG, S_RDY, S_SETUP, S_WAITB, S_DLOW, S_DHIGH,
    S_BLOW, S_BHIGH, S_DESEL, S_DCHK, S_DLOW2, S_DHIGH2,
    S_RBSEL, S_RBLOW, S_RBHIGH, S_RBOFF, S_TLOW, S_THIGH
  } stateE;

  stateE state, nxt;
  logic  finOk, finErr, hpEnd;
  failE  errCode;

  assign hpEnd = (stepCnt == HALF_LAST);

  always_comb begin
    nxt     = state;
    stb     = '0;
    finOk   = 1'b0;
    finErr  = 1'b0;
    errCode = FC_NONE;
    case (state)
      S_IDLE: if (start) begin
        stb.cntLoad = 1'b1;
        nxt = readMode ? S_RBSEL : S_PROG;
      end
      S_PROG: if (stepCnt == HOLD_LAST) begin
        stb.waitClr = 1'b1;
        nxt = S_RDY;
      end
      S_RDY: begin
        if (tgtInit && !tgtBusy) nxt = S_SETUP;
        else if (waitExpired) begin finErr = 1'b1; errCode = FC_READY; end
      end
      S_SETUP: nxt = cntZero ? S_DESEL : S_WAITB;
      S_WAITB: if (inValid) begin
        stb.takeByte = 1'b1;
        nxt = S_DLOW;
      end
      S_DLOW: if (hpEnd) begin
        stb.cntDec = 1'b1;
        nxt = S_DHIGH;
      end
      S_DHIGH: if (hpEnd) begin
        if (CHECK_BSY && tgtBusy) begin
          stb.waitClr = 1'b1;
          nxt = S_BLOW;
        end else nxt = cntZero ? S_DESEL : S_WAITB;
      end
      S_BLOW: if (hpEnd) nxt = S_BHIGH;
      S_BHIGH: if (hpEnd) begin
        if (!tgtBusy) nxt = cntZero ? S_DESEL : S_WAITB;
        else if (waitExpired) begin finErr = 1'b1; errCode = FC_BUSY; end
        else nxt = S_BLOW;
      end
      S_DESEL: begin
        stb.waitClr = 1'b1;
        nxt = S_DCHK;
      end
      S_DCHK: begin
        if (tgtDone) finOk = 1'b1;
        else if (waitExpired) begin finErr = 1'b1; errCode = FC_DONE; end
        else nxt = S_DLOW2;
      end
      S_DLOW2:  if (hpEnd) nxt = S_DHIGH2;
      S_DHIGH2: if (hpEnd) nxt = S_DCHK;
      S_RBSEL:  nxt = cntZero ? S_RBOFF : S_RBLOW;
      S_RBLOW: if (hpEnd) begin
        stb.cntDec = 1'b1;
        nxt = S_RBHIGH;
      end
      S_RBHIGH: if (hpEnd) begin
        stb.sampleByte = 1'b1;
        nxt = cntZero ? S_RBOFF : S_RBLOW;
      end
      S_RBOFF: if (hpEnd) nxt = S_TLOW;
      S_TLOW:  if (hpEnd) nxt = S_THIGH;
      S_THIGH: if (hpEnd) finOk = 1'b1;
      default: nxt = S_IDLE;
    endcase
    if (finOk || finErr) nxt = S_IDLE;
    stb.stepClr = (nxt != state);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      status   <= STAT_IDLE;
      failCode <= FC_NONE;
      abortOut <= 1'b0;
    end else begin
      state    <= nxt;
      abortOut <= finErr;
      if (state == S_IDLE && start) begin
        status   <= STAT_RUN;
        failCode <= FC_NONE;
      end else if (finOk) begin
        status   <= STAT_OK;
      end else if (finErr) begin
        status   <= STAT_ERR;
        failCode <= errCode;
      end
    end
  end

  // Moore decode of the port lines
  always_comb begin
    progOut = (state == S_PROG);
    selOut  = (state inside {S_SETUP, S_WAITB, S_DLOW, S_DHIGH, S_BLOW,
                             S_BHIGH, S_RBSEL, S_RBLOW, S_RBHIGH});
    wrOut   = (state inside {S_SETUP, S_WAITB, S_DLOW, S_DHIGH, S_BLOW,
                             S_BHIGH, S_DESEL});
    cfgClk  = !(state inside {S_DLOW, S_BLOW, S_DLOW2, S_RBLOW, S_TLOW});
    inReady = (state == S_WAITB);
  end

  // ---- checker state for the assertions below ----
  logic              clkPrev;
  logic [STEP_W-1:0] levelCnt;
  logic [STEP_W-1:0] progCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b1;
      levelCnt <= HALF_LAST;
      progCnt  <= '0;
    end else begin
      clkPrev <= cfgClk;
      if (cfgClk != clkPrev)   levelCnt <= '0;
      else if (levelCnt != '1) levelCnt <= levelCnt + 1'b1;
      if (!progOut)            progCnt <= '0;
      else if (progCnt != '1)  progCnt <= progCnt + 1'b1;
    end
  end

  // R12
  clk_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgClk != clkPrev) |-> (levelCnt >= HALF_LAST));

  // R1
  prog_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progOut) |-> (progCnt == STEP_W'(PROG_HOLD)));

  // R6
  desel_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(wrOut) && !abortOut) |-> ($past(selOut) == 1'b0));

  // R2
  abort_from_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortOut) |-> ($past(status) == STAT_RUN));

endmodule

// File: rtl/pcfg_master.sv
module pcfg_master
  import pcfg_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 20,
  parameter int HALF_CYC   = 2,
  parameter int PROG_HOLD  = 64,
  parameter int TIMEOUT    = 1000000,
  parameter int BUSY_CHECK = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              readMode,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              progOut,
  input  logic              tgtInit,
  input  logic              tgtBusy,
  input  logic              tgtDone,
  output logic              selOut,
  output logic              wrOut,
  output logic              cfgClk,
  output logic [DATA_W-1:0] cfgDout,
  input  logic [DATA_W-1:0] cfgDin,
  output logic              rbValid,
  output logic [DATA_W-1:0] rbData,
  output logic              abortOut,
  output logic [1:0]        status,
  output logic [1:0]        failCode
);

  localparam int STEP_MAX = (HALF_CYC > PROG_HOLD) ? HALF_CYC : PROG_HOLD;
  localparam int STEP_W   = $clog2(STEP_MAX + 1) + 1;
  localparam int WAIT_W   = $clog2(TIMEOUT + 1);

  strobeS            stb;
  logic [STEP_W-1:0] stepCnt;
  logic              cntZero, waitExpired;
  statE              statusE;
  failE              failE_q;

  pcfg_ctrl #(
    .HALF_CYC(HALF_CYC), .PROG_HOLD(PROG_HOLD),
    .BUSY_CHECK(BUSY_CHECK), .STEP_W(STEP_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .readMode(readMode),
    .tgtInit(tgtInit), .tgtBusy(tgtBusy), .tgtDone(tgtDone),
    .inValid(inValid), .stepCnt(stepCnt), .cntZero(cntZero),
    .waitExpired(waitExpired), .stb(stb), .progOut(progOut),
    .selOut(selOut), .wrOut(wrOut), .cfgClk(cfgClk), .inReady(inReady),
    .abortOut(abortOut), .status(statusE), .failCode(failE_q)
  );

  pcfg_dpath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .STEP_W(STEP_W),
    .TIMEOUT(TIMEOUT), .WAIT_W(WAIT_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cntInit(byteCount),
    .streamData(inData), .cfgDin(cfgDin), .stepCnt(stepCnt),
    .cntZero(cntZero), .waitExpired(waitExpired), .cfgDout(cfgDout),
    .rbData(rbData), .rbValid(rbValid)
  );

  assign status   = statusE;
  assign failCode = failE_q;

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cfgClk) && selOut && wrOut) |-> $stable(cfgDout));

  // R3
  ready_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (selOut && wrOut && cfgClk));

  // R8
  rb_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    rbValid |-> !wrOut);

endmodule

// File: tb/test_pcfg_master.sv
module test_pcfg_master;

  localparam int HALF = 2;
  localparam int HOLD = 3;
  localparam int TMO  = 20;
  localparam int CW   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0, readMode = 1'b0;
  logic [CW-1:0] byteCount = '0;
  logic          inValid = 1'b1;
  logic [7:0]    inData;
  logic          inReady, progOut, selOut, wrOut, cfgClk, rbValid, abortOut;
  logic          tgtInit, tgtBusy, tgtDone;
  logic [7:0]    cfgDout, cfgDin, rbData;
  logic [1:0]    status, failCode;

  pcfg_master #(
    .DATA_W(8), .CNT_W(CW), .HALF_CYC(HALF), .PROG_HOLD(HOLD),
    .TIMEOUT(TMO), .BUSY_CHECK(1)
  ) i_pcfg_master (
    .clk(clk), .rstN(rstN), .start(start), .readMode(readMode),
    .byteCount(byteCount), .inValid(inValid), .inData(inData),
    .inReady(inReady), .progOut(progOut), .tgtInit(tgtInit),
    .tgtBusy(tgtBusy), .tgtDone(tgtDone), .selOut(selOut), .wrOut(wrOut),
    .cfgClk(cfgClk), .cfgDout(cfgDout), .cfgDin(cfgDin),
    .rbValid(rbValid), .rbData(rbData), .abortOut(abortOut),
    .status(status), .failCode(failCode)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---- stream source ----
  int idx = 0, idxBase = 0;
  logic [7:0] seed = 8'h00;
  always_comb inData = seed + 8'((idx - idxBase) * 37);
  always @(posedge clk) if (inValid && inReady) idx <= idx + 1;

  // ---- target model ----
  int rdyDelay = 0, busyN = 0, doneN = 0;
  int capN = 0, capBase = 0, busyLeft = 0;
  int doneEdges = 0, doneBase = 0, rbEdge = 0, rbBase = 0;
  logic [7:0] cap [256];
  logic initOk = 1'b0;
  int rdyCnt = 0;

  assign tgtInit = initOk;
  assign tgtBusy = (capN != capBase) && (busyLeft != 0);
  assign tgtDone = ((doneEdges - doneBase) >= doneN);
  assign cfgDin  = 8'hA0 + 8'(rbEdge - rbBase);

  always @(posedge cfgClk) begin
    if (selOut && wrOut) begin
      if (!tgtBusy) begin
        cap[8'(capN)] <= cfgDout;
        capN     <= capN + 1;
        busyLeft <= busyN;
      end else if (busyLeft > 0) busyLeft <= busyLeft - 1;
    end
    if (!selOut && !wrOut && !progOut) doneEdges <= doneEdges + 1;
    if (selOut) rbEdge <= rbEdge + 1;
  end

  // ---- port monitor ----
  int cyc = 0, progRun = 0, lastProgW = 0, progRises = 0, aborts = 0;
  int selFallT = 0, wrFallT = 0, rbWrSeen = 0;
  int rbN = 0;
  logic [7:0] rbCap [256];
  bit rbMode = 1'b0;
  logic progPrev = 1'b0, selPrev = 1'b0, wrPrev = 1'b0;

  always @(negedge clk) begin
    if (progOut) begin
      progRun++;
      initOk = 1'b0;
      rdyCnt = 0;
    end else begin
      if (progPrev) lastProgW = progRun;
      progRun = 0;
      if (!initOk) begin
        if (rdyCnt >= rdyDelay) initOk = 1'b1;
        else rdyCnt++;
      end
    end
    if (progOut && !progPrev) progRises++;
    if (selPrev && !selOut) selFallT = cyc;
    if (wrPrev && !wrOut) wrFallT = cyc;
    if (abortOut) aborts++;
    if (rbMode && (wrOut || progOut)) rbWrSeen++;
    progPrev = progOut;
    selPrev  = selOut;
    wrPrev   = wrOut;
    cyc++;
  end

  always @(posedge clk) if (rbValid) begin
    rbCap[8'(rbN)] <= rbData;
    rbN <= rbN + 1;
  end

  task automatic waitEnd(input string req);
    for (int k = 0; k < 5000 && status < 2; k++) @(negedge clk);
    chk(status >= 2, req, "completion", status, 2);
    repeat (2) @(negedge clk);
  endtask

  task automatic runLoad(input int n, input int bN, input int dN, input int rD,
                         input logic [7:0] sd, input int expStat, input int expCode,
                         input bit restart);
    int abBase, riseBase;
    string reqB;
    reqB = (n == 0) ? "R11" : "R4";
    @(negedge clk);
    busyN = bN; doneN = dN; rdyDelay = rD; seed = sd;
    capBase = capN; doneBase = doneEdges; idxBase = idx;
    abBase = aborts; riseBase = progRises; rbMode = 1'b0;
    byteCount = CW'(n); readMode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(status == 1, "R1", "status running", status, 1);
    if (restart) begin
      wait (selOut);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    waitEnd("R7");
    chk(status == expStat, "R7", "final status", status, expStat);
    chk(failCode == expCode, (expCode == 2) ? "R5" : (expCode == 1) ? "R2" : "R7",
        "fail code", failCode, expCode);
    chk(aborts - abBase == ((expStat == 3) ? 1 : 0), "R2", "abort pulses",
        aborts - abBase, (expStat == 3) ? 1 : 0);
    chk(progRises - riseBase == 1, restart ? "R10" : "R1", "program pulses",
        progRises - riseBase, 1);
    chk(lastProgW == HOLD, "R1", "program width", lastProgW, HOLD);
    if (expStat == 2) begin
      chk(capN - capBase == n, reqB, "captured bytes", capN - capBase, n);
      for (int i = 0; i < n; i++) begin
        logic [7:0] e;
        e = sd + 8'(i * 37);
        chk(cap[8'(capBase + i)] == e, restart ? "R10" : "R4", "byte value",
            cap[8'(capBase + i)], e);
      end
      chk(wrFallT == selFallT + 1, "R6", "wr falls after sel", wrFallT - selFallT, 1);
      chk(doneEdges - doneBase == dN, "R7", "done-phase pulses",
          doneEdges - doneBase, dN);
    end
  endtask

  task automatic runRead(input int n);
    int vBase, wBase;
    @(negedge clk);
    rbBase = rbEdge; vBase = rbN; doneBase = doneEdges; doneN = 0;
    wBase = rbWrSeen; rbMode = 1'b1;
    byteCount = CW'(n); readMode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitEnd("R8");
    chk(status == 2, "R8", "read status", status, 2);
    chk(rbN - vBase == n, "R8", "read byte count", rbN - vBase, n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = 8'hA0 + 8'(i + 1);
      chk(rbCap[8'(vBase + i)] == e, "R8", "read byte value", rbCap[8'(vBase + i)], e);
    end
    chk(rbWrSeen == wBase, "R8", "write or program during read", rbWrSeen - wBase, 0);
    chk(doneEdges - doneBase == 1, "R8", "trailing pulse", doneEdges - doneBase, 1);
    rbMode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(status == 0, "R9", "status", status, 0);
    chk(failCode == 0, "R9", "failCode", failCode, 0);
    chk(!progOut && !selOut && !wrOut, "R9", "prog/sel/wr", {progOut, selOut, wrOut}, 0);
    chk(cfgClk == 1'b1, "R9", "cfgClk", cfgClk, 1);
    chk(!abortOut && !inReady && !rbValid, "R9", "abort/ready/valid",
        {abortOut, inReady, rbValid}, 0);

    // sweep: byte count x busy length x done latency
    for (int n = 0; n <= 4; n++)
      for (int b = 0; b <= 2; b++)
        for (int d = 0; d <= 2; d++)
          runLoad(n, b, d, n + b, 8'(n * 16 + b * 4 + d), 2, 0, 1'b0);

    // timeouts, one per wait
    runLoad(2, 0, 0, 1000, 8'h11, 3, 1, 1'b0);
    runLoad(2, 100, 0, 0, 8'h22, 3, 2, 1'b0);
    runLoad(3, 0, 100, 0, 8'h33, 3, 3, 1'b0);
    // recovery after failures, then restart attempt mid-load (R10)
    runLoad(3, 1, 1, 2, 8'h44, 2, 0, 1'b0);
    runLoad(4, 1, 2, 1, 8'h55, 2, 0, 1'b1);

    // read-back sweep
    for (int n = 0; n <= 4; n++) runRead(n);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule